// File: doc/BRIEF.md
# Microsecond Periodic Reload Timer

This block is a 16-bit periodic down-counter that sits behind a simple 32-bit register bus. A prescaler divides the system clock down to one tick per microsecond. Each tick lowers the count by one. When a tick finds the count at zero, the count is refilled from the reload register and a one-cycle wrap pulse is driven. Software controls it through three word registers: a control word, a reload value and the live count.

Bus accesses are single-cycle and always a full word. A write is taken on the clock edge at which `bus_sel` and `bus_wr` are both high. Read data is combinational: it is valid while `bus_sel` is high and `bus_wr` is low, and zero otherwise. Control bit 31 is a self-clearing soft reset. Control bit 0 starts the counter. The counter then keeps running until a soft reset or a hardware reset, even if bit 0 is later written as zero.

Top module: `usec_reload_timer`

## Requirements
- R1: After hardware reset (`rst_n` low), the control, reload and count registers read 0, the counter is stopped and `wrap_pulse` is low.
- R2: A write to offset 0x08 keeps only bits 15:0 as the reload value. A read of offset 0x08 returns that value with bits 31:16 zero.
- R3: A write to offset 0x08 also loads the written 16-bit value into the count and restarts the tick phase. A read of offset 0x0C returns the live count with bits 31:16 zero.
- R4: Writes to offset 0x0C are ignored, and the count read back afterwards is unchanged.
- R5: Offsets other than 0x00, 0x08 and 0x0C read as 0. Writes to them change no register.
- R6: A write to offset 0x00 with bit 31 clear stores all 32 written bits, and they read back at 0x00. If bit 0 is clear and the counter is stopped, the counter stays stopped.
- R7: A write to offset 0x00 with bit 0 set and bit 31 clear starts a stopped counter. Ticks then come every DIV = CLK_HZ/TICK_HZ clocks, the first one DIV clocks after the write edge, and each tick lowers the count by one.
- R8: A tick that finds the count at zero reloads it and raises `wrap_pulse` for exactly one cycle. With reload value N, wraps appear (N+1)*DIV clocks apart, the first one (N+1)*DIV clocks after the start edge when the count was N.
- R9: A write to offset 0x00 with bit 0 clear does not stop a running counter.
- R10: A write to offset 0x00 with bit 31 set takes priority over every other bit. It stops the counter and clears control and reload to 0. The count holds its value, and the rest of the written word is discarded.
- R11: With a reload value of 0, the count stays at 0 and `wrap_pulse` fires on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset within the 256-byte window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when no read |
| wrap_pulse | output | 1 | One-cycle pulse on each count wrap |

## Verification
The assertions assume that every access is word-aligned and lasts a single cycle. They also assume that read data is meaningful only while a read strobe is present, and that the divide ratio is at least two, so that two wraps can never fall on consecutive cycles. The stimulus issues each access as a one-cycle strobe followed by idle cycles. It uses only the aligned offsets, and it runs at the default ratio of 250 clocks per tick. Expected wrap cycles are derived from the start edge and the reload value, so the scoreboard catches a wrap that comes early, comes late, is missing or is extra.

// File: rtl/usec_reload_timer.sv
module usec_reload_timer #(
  parameter int unsigned CLK_HZ  = 250_000_000,
  parameter int unsigned TICK_HZ = 1_000_000,
  parameter int unsigned CNT_W   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wrap_pulse
);
  localparam int unsigned DIV   = CLK_HZ / TICK_HZ;
  localparam int unsigned PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [7:0] OFF_CTRL   = 8'h00;
  localparam logic [7:0] OFF_RELOAD = 8'h08;
  localparam logic [7:0] OFF_COUNT  = 8'h0C;
  localparam int ENA_BIT = 0;
  localparam int RST_BIT = 31;

  logic [31:0]      ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count_q;
  logic [PRE_W-1:0] pre_q;
  logic             running;

  logic wr_ctrl, wr_reload, soft_rst, start, tick;
  assign wr_ctrl   = bus_sel && bus_wr && (bus_addr == OFF_CTRL);
  assign wr_reload = bus_sel && bus_wr && (bus_addr == OFF_RELOAD);
  assign soft_rst  = wr_ctrl && bus_wdata[RST_BIT];
  assign start     = wr_ctrl && !bus_wdata[RST_BIT] && bus_wdata[ENA_BIT] && !running;
  assign tick      = running && (pre_q == PRE_W'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      running <= 1'b0;
    end else if (soft_rst) begin
      ctrl_q  <= '0;
      running <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl_q <= bus_wdata;
      if (bus_wdata[ENA_BIT]) running <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload_q <= '0;
    else if (soft_rst)  reload_q <= '0;
    else if (wr_reload) reload_q <= bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   pre_q <= '0;
    else if (soft_rst || start || wr_reload || tick) pre_q <= '0;
    else if (running)                             pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q    <= '0;
      wrap_pulse <= 1'b0;
    end else begin
      wrap_pulse <= tick && (count_q == '0);
      if (wr_reload)  count_q <= bus_wdata[CNT_W-1:0];
      else if (tick)  count_q <= (count_q == '0) ? reload_q : count_q - 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        OFF_CTRL:   bus_rdata = ctrl_q;
        OFF_RELOAD: bus_rdata = 32'(reload_q);
        OFF_COUNT:  bus_rdata = 32'(count_q);
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/usec_reload_timer_chk.sv
module usec_reload_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [7:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic             wrap_pulse,
  input logic             running,
  input logic [31:0]      ctrl_q,
  input logic [CNT_W-1:0] reload_q,
  input logic [CNT_W-1:0] count_q
);
  logic rd, wr;
  assign rd = bus_sel && !bus_wr;
  assign wr = bus_sel && bus_wr;

  assert_wrap_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |=> !wrap_pulse);

  assert_reload_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == 8'h08) |-> ((bus_rdata >> CNT_W) == 32'd0));

  assert_count_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == 8'h0C) |-> ((bus_rdata >> CNT_W) == 32'd0));

  assert_unmapped_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr != 8'h00 && bus_addr != 8'h08 && bus_addr != 8'h0C) |-> bus_rdata == 32'd0);

  assert_soft_reset_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == 8'h00 && bus_wdata[31]) |=> (!running && ctrl_q == 32'd0 && reload_q == '0));

  assert_idle_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !(wr && bus_addr == 8'h08)) |=> $stable(count_q));

  assert_enable_clear_keeps_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && wr && bus_addr == 8'h00 && !bus_wdata[31]) |=> running);
endmodule

bind usec_reload_timer usec_reload_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .wrap_pulse(wrap_pulse), .running(running), .ctrl_q(ctrl_q),
  .reload_q(reload_q), .count_q(count_q)
);

// File: tb/usec_reload_timer_tb.sv
`timescale 1ns/1ps
module usec_reload_timer_tb;
  localparam int DIV = 250;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wrap_pulse;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  usec_reload_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wrap_pulse(wrap_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, output int edge_c);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    edge_c = cyc;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Scoreboard monitor: every wrap must match the next expected cycle.
  always @(negedge clk) begin
    if (rst_n) begin
      if (exp_q.size() > 0 && cyc > exp_q[0]) begin
        check("R8 missed wrap", 32'(cyc), 32'(exp_q[0]));
        void'(exp_q.pop_front());
      end
      if (wrap_pulse) begin
        if (exp_q.size() == 0) check("R8/R10 unexpected wrap", 32'(cyc), 32'hFFFF_FFFF);
        else check("R8 wrap cycle", 32'(cyc), 32'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    #(100000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int e, e2, t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    bus_read(8'h00, d); check("R1 ctrl", d, 32'h0);
    bus_read(8'h08, d); check("R1 reload", d, 32'h0);
    bus_read(8'h0C, d); check("R1 count", d, 32'h0);
    check("R1 wrap", 32'(wrap_pulse), 32'h0);

    bus_write(8'h08, 32'h1234_ABCD, t);
    bus_read(8'h08, d); check("R2 reload mask", d, 32'h0000_ABCD);
    bus_read(8'h0C, d); check("R3 count loaded", d, 32'h0000_ABCD);

    bus_write(8'h0C, 32'h0000_0055, t);
    bus_read(8'h0C, d); check("R4 count write ignored", d, 32'h0000_ABCD);

    bus_write(8'h04, 32'hFFFF_FFFF, t);
    bus_read(8'h04, d); check("R5 unmapped read", d, 32'h0);
    bus_read(8'h10, d); check("R5 unmapped read 0x10", d, 32'h0);
    bus_read(8'h00, d); check("R5 ctrl untouched", d, 32'h0);
    bus_read(8'h08, d); check("R5 reload untouched", d, 32'h0000_ABCD);

    bus_write(8'h00, 32'h25A5_0000, t);
    bus_read(8'h00, d); check("R6 ctrl full word", d, 32'h25A5_0000);
    wait_until(t + 2 * DIV);
    bus_read(8'h0C, d); check("R6 stays stopped", d, 32'h0000_ABCD);

    bus_write(8'h08, 32'd3, t);
    bus_write(8'h00, 32'h0000_0001, e);
    for (int k = 1; k <= 4; k++) exp_q.push_back(e + 4 * DIV * k);
    wait_until(e + DIV + 4);
    bus_read(8'h0C, d); check("R7 one tick after DIV", d, 32'd2);
    bus_read(8'h00, d); check("R7 ctrl enable", d, 32'h1);

    wait_until(e + 5 * DIV + 9);
    bus_write(8'h00, 32'h0000_0000, t);
    bus_read(8'h00, d); check("R9 ctrl cleared by write", d, 32'h0);
    wait_until(e + 9 * DIV + 4);
    bus_read(8'h0C, d); check("R9 still counting", d, 32'd2);

    wait_until(e + 17 * DIV + 9);
    bus_write(8'h00, 32'h8000_0001, t);
    bus_read(8'h00, d); check("R10 ctrl cleared", d, 32'h0);
    bus_read(8'h08, d); check("R10 reload cleared", d, 32'h0);
    bus_read(8'h0C, d); check("R10 count held", d, 32'd2);
    wait_until(t + 6 * DIV);
    bus_read(8'h0C, d); check("R10 stopped despite enable bit", d, 32'd2);
    check("R8 all wraps seen", 32'(exp_q.size()), 32'h0);

    bus_write(8'h08, 32'd0, t);
    bus_write(8'h00, 32'h0000_0001, e2);
    for (int k = 1; k <= 3; k++) exp_q.push_back(e2 + DIV * k);
    wait_until(e2 + DIV + 6);
    bus_read(8'h0C, d); check("R11 count stays zero", d, 32'h0);
    wait_until(e2 + 3 * DIV + 9);
    bus_write(8'h00, 32'h8000_0000, t);
    wait_until(t + 2 * DIV);
    check("R11 pulse each tick", 32'(exp_q.size()), 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule